// File: doc/BRIEF.md
# ATX Supply Power-On Sequencer

This block runs from the always-on standby rail of a small single-board computer and controls an ATX power supply. It debounces the front-panel power button and drives the active-low supply-enable output. It waits for the supply to report power-good, then walks through a fixed series of boot stages. Finally it raises a RUN handshake to the downstream system controller and waits a bounded time for that controller to show signs of life.

The supply turns on when the button is released after a press, never on the press itself. Peripheral bring-up (display, keyboard, audio) sits outside this block and reports back through a single stage-done input. Once the system is operational, holding the button long enough forces the supply off and returns the block to standby. Losing power-good at any point after bring-up starts also returns it to standby and records a fault. All time windows are parameters counted in clock cycles.

Top module: `atx_seq_ctrl`

## Requirements
- R1: After reset, `stage` is 0, `pc_on_n` is 1, `run` is 0, and `booted`, `timeout_flag` and `fault_flag` are all 0.
- R2: A debounced press by itself does not enable the supply. The release that follows a press drives `pc_on_n` low while `stage` stays 0.
- R3: A button pulse shorter than `DEB_CYCLES` clock cycles, after the two-flop synchroniser, is ignored and does not power the supply on.
- R4: With the supply enabled, `stage` stays 0 until the synchronised `pwr_good` is high. It then moves to 1, with `run` still 0.
- R5: In stage 1, a high `periph_done` moves the block to stage 2 and raises `run`. `run` is high only in stages 2 and 3.
- R6: In stage 2, an `alive_pulse` moves the block to stage 3 and sets `booted`, with `run` kept high.
- R7: If `ALIVE_CYCLES` cycles pass in stage 2 without an `alive_pulse`, `timeout_flag` sets. The block stays in stage 2 with `run` high and the supply on. A later `alive_pulse` still completes the boot, and the flag stays set.
- R8: In stage 3, holding the debounced button for `HOLD_CYCLES` cycles drives `pc_on_n` high and `run` low and returns to stage 0. A shorter hold has no effect.
- R9: After a forced power-off all flags are clear. A button that is still held, or its later release, does not power the supply back on; a fresh press and release is needed.
- R10: A loss of `pwr_good` in stages 1, 2 or 3 clears `run`, drives `pc_on_n` high, returns to stage 0 and sets `fault_flag`. The flag clears when the next power-on release is accepted.
- R11: `stage` is a 2-bit code: 0 means standby or waiting for the supply, 1 means peripheral init, 2 means RUN handoff, and 3 means operational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Raw front-panel power button, 1 = pressed |
| pwr_good | input | 1 | Supply power-good, asynchronous |
| periph_done | input | 1 | Peripheral initialisation finished (synchronous) |
| alive_pulse | input | 1 | Activity strobe from downstream controller (synchronous) |
| pc_on_n | output | 1 | Active-low supply enable |
| run | output | 1 | Boot handshake to downstream controller |
| stage | output | 2 | Boot stage code |
| booted | output | 1 | Boot sequence complete |
| timeout_flag | output | 1 | Sticky: no activity within the alive window |
| fault_flag | output | 1 | Sticky: power-good lost while supply enabled |

## Verification
A wrong state register shows up within one cycle as an inconsistent set of `stage`, `run` and `pc_on_n`. One example is `run` high in stage 1, or the supply enabled while the block claims standby. Faults in the timers appear only at the end of a window: `timeout_flag` sets early or late around `ALIVE_CYCLES`, or a forced shutdown fires on a hold shorter than `HOLD_CYCLES`. The bench therefore samples a few cycles on each side of every window. A debounce or edge-detect fault shows as the supply turning on after a glitch, on a press instead of a release, or after the release of a button held through a forced shutdown.

// File: rtl/atx_seq_pkg.sv
package atx_seq_pkg;

    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_ARMED    = 3'd1,
        ST_WAIT_PG  = 3'd2,
        ST_INIT     = 3'd3,
        ST_RUN_WAIT = 3'd4,
        ST_ON       = 3'd5
    } seq_state_t;

    typedef logic [1:0] stage_code_t;

    localparam stage_code_t STAGE_STANDBY = 2'd0;
    localparam stage_code_t STAGE_PERIPH  = 2'd1;
    localparam stage_code_t STAGE_HANDOFF = 2'd2;
    localparam stage_code_t STAGE_OPER    = 2'd3;

    typedef struct packed {
        logic        pc_on_n;
        logic        run;
        stage_code_t stage;
        logic        booted;
    } seq_drive_t;

    function automatic logic supply_live(seq_state_t s);
        return (s == ST_INIT) || (s == ST_RUN_WAIT) || (s == ST_ON);
    endfunction

    function automatic seq_drive_t decode_state(seq_state_t s);
        seq_drive_t d;
        d = '{pc_on_n: 1'b1, run: 1'b0, stage: STAGE_STANDBY, booted: 1'b0};
        case (s)
            ST_WAIT_PG:  d.pc_on_n = 1'b0;
            ST_INIT: begin
                d.pc_on_n = 1'b0;
                d.stage   = STAGE_PERIPH;
            end
            ST_RUN_WAIT: begin
                d.pc_on_n = 1'b0;
                d.run     = 1'b1;
                d.stage   = STAGE_HANDOFF;
            end
            ST_ON: begin
                d.pc_on_n = 1'b0;
                d.run     = 1'b1;
                d.stage   = STAGE_OPER;
                d.booted  = 1'b1;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/atx_btn_filter.sv
module atx_btn_filter
    import atx_seq_pkg::*;
#(
    parameter int unsigned DEB_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl_q;
    logic                   lvl_prev_q;
    logic [CW-1:0]          cnt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= '0;
            lvl_q      <= 1'b0;
            lvl_prev_q <= 1'b0;
            cnt_q      <= '0;
        end else begin
            sync_q     <= {sync_q[SYNC_STAGES-2:0], raw_i};
            lvl_prev_q <= lvl_q;
            if (synced == lvl_q) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                lvl_q <= synced;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_o = lvl_q;
    assign rise_o  = lvl_q & ~lvl_prev_q;
    assign fall_o  = ~lvl_q & lvl_prev_q;

    // the filtered level only ever adopts the synchronised value (R3)
    assert_deb_follows_sync_R3: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(synced)));

endmodule

// File: rtl/atx_cycle_timer.sv
module atx_cycle_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          en_i,
    output logic [TW-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i || !en_i) begin
            count_o <= '0;
        end else if (count_o != {TW{1'b1}}) begin
            count_o <= count_o + 1'b1;
        end
    end

    // counter only steps by one or holds; it never wraps (R7, R8)
    assert_timer_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (count_o != '0) |-> (($past(count_o) == count_o - 1'b1) || ($past(count_o) == count_o)));

endmodule

// File: rtl/atx_seq_fsm.sv
module atx_seq_fsm
    import atx_seq_pkg::*;
#(
    parameter int unsigned ALIVE_CYCLES = 250_000_000,
    parameter int unsigned HOLD_CYCLES  = 500_000_000,
    parameter int unsigned TW           = 29
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          btn_level_i,
    input  logic          btn_rise_i,
    input  logic          btn_fall_i,
    input  logic          pg_i,
    input  logic          periph_done_i,
    input  logic          alive_i,
    input  logic [TW-1:0] tcount_i,
    output seq_state_t    state_o,
    output logic          timer_en_o,
    output logic          timer_clr_o,
    output logic          timeout_o,
    output logic          fault_o
);
    localparam logic [TW-1:0] ALIVE_LAST = TW'(ALIVE_CYCLES - 1);
    localparam logic [TW-1:0] HOLD_LAST  = TW'(HOLD_CYCLES - 1);

    seq_state_t state_q, state_d;
    logic       pg_lost;
    logic       window_end;

    assign pg_lost    = supply_live(state_q) && !pg_i;
    assign window_end = (state_q == ST_RUN_WAIT) && (tcount_i == ALIVE_LAST) && !alive_i;

    always_comb begin
        state_d = state_q;
        if (pg_lost) begin
            state_d = ST_OFF;
        end else begin
            case (state_q)
                ST_OFF:      if (btn_rise_i)    state_d = ST_ARMED;
                ST_ARMED:    if (btn_fall_i)    state_d = ST_WAIT_PG;
                ST_WAIT_PG:  if (pg_i)          state_d = ST_INIT;
                ST_INIT:     if (periph_done_i) state_d = ST_RUN_WAIT;
                ST_RUN_WAIT: if (alive_i)       state_d = ST_ON;
                ST_ON:       if (btn_level_i && tcount_i == HOLD_LAST) state_d = ST_OFF;
                default:                        state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_OFF;
            timeout_o <= 1'b0;
            fault_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_OFF)
                timeout_o <= 1'b0;
            else if (window_end)
                timeout_o <= 1'b1;
            if (pg_lost)
                fault_o <= 1'b1;
            else if (state_q == ST_ARMED && state_d == ST_WAIT_PG)
                fault_o <= 1'b0;
        end
    end

    assign state_o     = state_q;
    assign timer_en_o  = (state_q == ST_RUN_WAIT) || (state_q == ST_ON && btn_level_i);
    assign timer_clr_o = (state_d != state_q);

    // supply is enabled only after a release that followed an armed press (R2)
    assert_release_starts_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_PG && $past(state_q) != ST_WAIT_PG) |-> ($past(state_q) == ST_ARMED));

    // without power-good the block never leaves the supply wait (R4)
    assert_hold_for_pg_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_PG && !pg_i) |=> (state_q == ST_WAIT_PG));

    // handoff stage never falls back to peripheral init (R6)
    assert_handoff_forward_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN_WAIT) |=> (state_q inside {ST_RUN_WAIT, ST_ON, ST_OFF}));

    // timeout flag can only rise out of the handoff stage (R7)
    assert_timeout_in_handoff_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> ($past(state_q) == ST_RUN_WAIT));

    // with button released and supply good, operation persists (R8)
    assert_no_spurious_off_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ON && pg_i && !btn_level_i) |=> (state_q == ST_ON));

    // losing power-good drops to standby with a fault recorded (R10)
    assert_pg_loss_R10: assert property (@(posedge clk) disable iff (rst)
        (supply_live(state_q) && !pg_i) |=> (state_q == ST_OFF && fault_o));

endmodule

// File: rtl/atx_seq_ctrl.sv
module atx_seq_ctrl
    import atx_seq_pkg::*;
#(
    parameter int unsigned DEB_CYCLES   = 1_000_000,
    parameter int unsigned ALIVE_CYCLES = 250_000_000,
    parameter int unsigned HOLD_CYCLES  = 500_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_raw,
    input  logic       pwr_good,
    input  logic       periph_done,
    input  logic       alive_pulse,
    output logic       pc_on_n,
    output logic       run,
    output logic [1:0] stage,
    output logic       booted,
    output logic       timeout_flag,
    output logic       fault_flag
);
    localparam int unsigned TMAX = (ALIVE_CYCLES > HOLD_CYCLES) ? ALIVE_CYCLES : HOLD_CYCLES;
    localparam int unsigned TW   = $clog2(TMAX + 1);

    logic [SYNC_STAGES-1:0] pg_sync_q;
    logic                   btn_level, btn_rise, btn_fall;
    logic                   t_en, t_clr;
    logic [TW-1:0]          t_count;
    seq_state_t             state;
    seq_drive_t             drv;

    always_ff @(posedge clk) begin
        if (rst) pg_sync_q <= '0;
        else     pg_sync_q <= {pg_sync_q[SYNC_STAGES-2:0], pwr_good};
    end

    atx_btn_filter #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (btn_raw),
        .level_o (btn_level),
        .rise_o  (btn_rise),
        .fall_o  (btn_fall)
    );

    atx_cycle_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (t_clr),
        .en_i    (t_en),
        .count_o (t_count)
    );

    atx_seq_fsm #(
        .ALIVE_CYCLES (ALIVE_CYCLES),
        .HOLD_CYCLES  (HOLD_CYCLES),
        .TW           (TW)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .btn_level_i   (btn_level),
        .btn_rise_i    (btn_rise),
        .btn_fall_i    (btn_fall),
        .pg_i          (pg_sync_q[SYNC_STAGES-1]),
        .periph_done_i (periph_done),
        .alive_i       (alive_pulse),
        .tcount_i      (t_count),
        .state_o       (state),
        .timer_en_o    (t_en),
        .timer_clr_o   (t_clr),
        .timeout_o     (timeout_flag),
        .fault_o       (fault_flag)
    );

    assign drv     = decode_state(state);
    assign pc_on_n = drv.pc_on_n;
    assign run     = drv.run;
    assign stage   = drv.stage;
    assign booted  = drv.booted;

    // RUN is never presented to the downstream controller while unpowered (R5)
    assert_run_powered_R5: assert property (@(posedge clk) disable iff (rst)
        run |-> (!pc_on_n && pg_sync_q[SYNC_STAGES-1] || $past(run)));

endmodule

// File: tb/sim_atx_seq_ctrl.sv
module sim_atx_seq_ctrl;

    localparam int DEB   = 8;
    localparam int ALIVE = 200;
    localparam int HOLD  = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_raw = 1'b0;
    logic       pwr_good = 1'b0;
    logic       periph_done = 1'b0;
    logic       alive_pulse = 1'b0;
    logic       pc_on_n, run, booted, timeout_flag, fault_flag;
    logic [1:0] stage;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    atx_seq_ctrl #(
        .DEB_CYCLES   (DEB),
        .ALIVE_CYCLES (ALIVE),
        .HOLD_CYCLES  (HOLD)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .btn_raw      (btn_raw),
        .pwr_good     (pwr_good),
        .periph_done  (periph_done),
        .alive_pulse  (alive_pulse),
        .pc_on_n      (pc_on_n),
        .run          (run),
        .stage        (stage),
        .booted       (booted),
        .timeout_flag (timeout_flag),
        .fault_flag   (fault_flag)
    );

    // expected outputs derived from the stage code definition (R11)
    function automatic bit exp_run(int stg);
        return stg >= 2;
    endfunction

    function automatic bit exp_pc_on_n(int stg, bit supply_req);
        return (stg == 0) ? !supply_req : 1'b0;
    endfunction

    function automatic bit exp_booted(int stg);
        return stg == 3;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_stage(string req, int stg, bit supply_req);
        chk(req, "stage", int'(stage), stg);
        chk(req, "pc_on_n", int'(pc_on_n), int'(exp_pc_on_n(stg, supply_req)));
        chk(req, "run", int'(run), int'(exp_run(stg)));
        chk(req, "booted", int'(booted), int'(exp_booted(stg)));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // press then release; supply request expected only after release (R2)
    task automatic press_release();
        btn_raw = 1'b1;
        tick(DEB + 10);
        chk("R2", "pc_on_n after press", int'(pc_on_n), 1);
        btn_raw = 1'b0;
        tick(DEB + 10);
        chk_stage("R2", 0, 1'b1);
        chk("R10", "fault cleared on power-on", int'(fault_flag), 0);
    endtask

    task automatic reach_stage2();
        press_release();
        tick(5);
        chk_stage("R4", 0, 1'b1);
        pwr_good = 1'b1;
        tick(4);
        chk_stage("R4", 1, 1'b1);
        periph_done = 1'b1;
        tick(1);
        periph_done = 1'b0;
        chk_stage("R5", 2, 1'b1);
    endtask

    task automatic pulse_alive();
        alive_pulse = 1'b1;
        tick(1);
        alive_pulse = 1'b0;
    endtask

    task automatic force_off();
        btn_raw = 1'b1;
        tick(HOLD + DEB + 10);
        chk_stage("R8", 0, 1'b0);
        chk("R9", "timeout cleared", int'(timeout_flag), 0);
        chk("R9", "fault clear", int'(fault_flag), 0);
        pwr_good = 1'b0;
        tick(50);
        chk_stage("R9", 0, 1'b0);
        btn_raw = 1'b0;
        tick(DEB + 10);
        chk_stage("R9", 0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        tick(5);
        rst = 1'b0;
        tick(1);
        chk_stage("R1", 0, 1'b0);
        chk("R1", "timeout_flag", int'(timeout_flag), 0);
        chk("R1", "fault_flag", int'(fault_flag), 0);

        // short glitches must not start the supply (R3)
        for (int i = 0; i < 6; i++) begin
            btn_raw = 1'b1;
            tick(1 + int'($urandom % (DEB - 2)));
            btn_raw = 1'b0;
            tick(DEB + 4);
            chk_stage("R3", 0, 1'b0);
        end

        // directed: normal boot, short hold, long hold
        reach_stage2();
        tick(5 + int'($urandom % (ALIVE - 30)));
        chk("R6", "timeout before alive", int'(timeout_flag), 0);
        pulse_alive();
        chk_stage("R6", 3, 1'b1);
        btn_raw = 1'b1;
        tick(HOLD - 40);
        btn_raw = 1'b0;
        tick(DEB + 10);
        chk_stage("R8", 3, 1'b1);
        force_off();

        // directed: alive window expiry edges (R7)
        reach_stage2();
        tick(ALIVE - 5);
        chk("R7", "timeout before window", int'(timeout_flag), 0);
        tick(10);
        chk("R7", "timeout after window", int'(timeout_flag), 1);
        chk_stage("R7", 2, 1'b1);
        pulse_alive();
        chk_stage("R7", 3, 1'b1);
        chk("R7", "timeout sticky", int'(timeout_flag), 1);

        // directed: power-good loss while operational (R10)
        pwr_good = 1'b0;
        tick(4);
        chk_stage("R10", 0, 1'b0);
        chk("R10", "fault set", int'(fault_flag), 1);
        tick(20);
        chk("R10", "fault held", int'(fault_flag), 1);

        // random scenarios
        for (int it = 0; it < 8; it++) begin
            int sc;
            sc = int'($urandom % 3);
            press_release();
            pwr_good = 1'b1;
            tick(4);
            chk_stage("R4", 1, 1'b1);
            if (sc == 0) begin
                tick(int'($urandom % 20));
                pwr_good = 1'b0;
                tick(4);
                chk_stage("R10", 0, 1'b0);
                chk("R10", "fault stage1", int'(fault_flag), 1);
            end else begin
                tick(int'($urandom % 20));
                periph_done = 1'b1;
                tick(1);
                periph_done = 1'b0;
                chk_stage("R5", 2, 1'b1);
                if (sc == 1) begin
                    tick(int'($urandom % (ALIVE - 20)));
                    pwr_good = 1'b0;
                    tick(4);
                    chk_stage("R10", 0, 1'b0);
                    chk("R10", "fault stage2", int'(fault_flag), 1);
                end else begin
                    tick(1 + int'($urandom % (ALIVE - 30)));
                    pulse_alive();
                    chk_stage("R6", 3, 1'b1);
                    force_off();
                end
            end
            tick(10);
        end

        finish_run();
    end

endmodule